// File: doc/BRIEF.md
# I2C SCL Phase and Data-Setup Timing Generator

This block produces the clock timing for an I2C master from the system clock. A 16-bit rate count sets the length of one count period. The speed mode decides how a full SCL cycle is split into periods. Standard mode spends one period low and one period high. The three faster modes spend two periods low and one period high. The block drives its own SCL level and marks the first cycle of each low phase and each high phase with tick enables. A transaction engine uses those ticks to step its bit sequencing.

The generator watches the SCL level on the bus. While it has released SCL but the line still reads low, a slave is stretching the clock. During that time the high-phase count freezes, and a flag reports the stretch. When a high phase has been stretched, the SDA-change tick in the next low phase waits for a programmable setup count plus one cycle, measured from the falling edge. The low phase is extended if it would otherwise end before that tick.

The rate and setup values arrive as 32-bit register words. The rate count is in bits 15:0. Bits 31:16 of the rate word hold a high-speed count that is stored elsewhere and not used here. The setup count is in bits 31:16 of its word.

Top module: `scl_timing_gen`

## Requirements
- R1: While reset is asserted, or when `en` is low at a clock edge, the next cycle shows `sclOut`=1 with all ticks and `stretchHold` at 0. After `en` rises, the first low phase begins one clock edge later.
- R2: The count period P is `rateWord[15:0]` system-clock cycles. A value of 0 is used as P=1. Bits 31:16 of `rateWord` have no effect on any output.
- R3: With `speedMode`=0 (standard), and with no stretching, SCL is low for exactly P cycles and high for exactly P cycles.
- R4: With `speedMode` equal to 1 (fast), 2 (fast-plus) or 3 (high-speed), and with no stretching, SCL is low for 2P cycles and high for P cycles.
- R5: `sclFallTick` is 1 only in the first cycle of each low phase. `sclRiseTick` is 1 only in the first cycle of each high phase.
- R6: During a high phase, a cycle in which `sclIn` reads 0 does not count toward P, and `stretchHold` is 1 in exactly those cycles.
- R7: If the preceding high phase had no stretched cycle, or if the low phase is the first one after enable, `sdaTick` is 1 in the first cycle of the low phase.
- R8: If the preceding high phase had one or more stretched cycles, `sdaTick` is 1 in low-phase cycle S+1 and in no other cycle of that phase, where S = `setupWord[31:16]` and cycle 0 is the first low cycle. The low phase then lasts max(L, S+2) cycles, where L is the low length set by R3 or R4.
- R9: Bits 15:0 of `setupWord` have no effect on any output.
- R10: Deasserting `en` in any phase returns the block to the idle state after the next clock edge, with SCL released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low forces idle |
| rateWord | input | 32 | Rate word; bits 15:0 hold the count P, bits 31:16 are not used |
| setupWord | input | 32 | Setup word; bits 31:16 hold the setup count S |
| speedMode | input | 2 | 0 standard, 1 fast, 2 fast-plus, 3 high-speed |
| sclIn | input | 1 | SCL level sampled from the bus |
| sclOut | output | 1 | SCL drive: 0 pulls low, 1 releases |
| sclFallTick | output | 1 | First cycle of a low phase |
| sclRiseTick | output | 1 | First cycle of a high phase |
| sdaTick | output | 1 | Cycle in which SDA may change |
| stretchHold | output | 1 | High phase frozen by a slave holding SCL low |

## Verification
The assertions check four things on every cycle:
- A disabled enable always leads to the idle state.
- A held-low SCL never ends a high phase, and the high count moves only when SCL reads high.
- Every falling edge of the SCL drive carries a fall tick.
- The SDA tick is immediate or delayed according to whether the previous high phase was stretched.

The exact phase lengths for each speed mode are shown only by the bench's scenarios, because they are compared with a behavioural reference cycle by cycle. The same holds for the treatment of a zero rate, for the extension of the low phase by a long setup count, and for the insensitivity to the unused halves of both words.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  typedef struct packed {
    logic clrAll;
    logic enterLow;
    logic enterHigh;
    logic incLow;
    logic incHigh;
  } strobes_t;
endpackage

// File: rtl/sclgen_dp.sv
module sclgen_dp
  import sclgen_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic              sclIn,
  input  logic [WORD_W-1:0] rateWord,
  input  logic [WORD_W-1:0] setupWord,
  input  logic [1:0]        speedMode,
  output logic              lowLast,
  output logic              highLast,
  output logic              sdaFire,
  output logic              sdaDone
);
  localparam int LEN_W     = CNT_W + 1;
  localparam int SETUP_LSB = WORD_W - CNT_W;

  logic [CNT_W-1:0] rateField, setupField, hiCnt;
  logic [LEN_W-1:0] period, lowLen, lowCnt, setupLeft;
  logic             stretched;

  assign rateField  = rateWord[CNT_W-1:0];
  assign setupField = setupWord[WORD_W-1:SETUP_LSB];
  assign period     = (rateField == '0) ? LEN_W'(1) : {1'b0, rateField};
  assign lowLen     = (speedMode == 2'd0) ? period : (period << 1);

  assign lowLast  = (lowCnt + LEN_W'(1)) >= lowLen;
  assign highLast = sclIn && (({1'b0, hiCnt} + LEN_W'(1)) == period);
  assign sdaFire  = (setupLeft == '0) && !sdaDone;

  always_ff @(posedge clk) begin
    if (!rstN || stb.clrAll) begin
      lowCnt    <= '0;
      hiCnt     <= '0;
      setupLeft <= '0;
      sdaDone   <= 1'b0;
      stretched <= 1'b0;
    end else begin
      if (stb.enterLow) begin
        lowCnt    <= '0;
        sdaDone   <= 1'b0;
        stretched <= 1'b0;
        setupLeft <= stretched ? ({1'b0, setupField} + LEN_W'(1)) : '0;
      end
      if (stb.incLow) begin
        lowCnt <= lowCnt + LEN_W'(1);
        if (setupLeft != '0) setupLeft <= setupLeft - LEN_W'(1);
        if (sdaFire) sdaDone <= 1'b1;
      end
      if (stb.enterHigh) begin
        hiCnt     <= '0;
        stretched <= 1'b0;
        sdaDone   <= 1'b1;
      end
      if (stb.incHigh) begin
        if (sclIn) hiCnt <= hiCnt + CNT_W'(1);
        else       stretched <= 1'b1;
      end
    end
  end

  assert_sda_prompt_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.enterLow && !stretched) |=> sdaFire);
  assert_sda_delayed_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.enterLow && stretched) |=> !sdaFire);
  assert_high_frozen_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.incHigh && !sclIn) |=> $stable(hiCnt));
  assert_high_counts_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.incHigh && sclIn) |=> (hiCnt == $past(hiCnt) + CNT_W'(1)));
endmodule

// File: rtl/sclgen_ctrl.sv
module sclgen_ctrl
  import sclgen_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     en,
  input  logic     sclIn,
  input  logic     lowLast,
  input  logic     highLast,
  input  logic     sdaFire,
  input  logic     sdaDone,
  output strobes_t stb,
  output logic     sclOut,
  output logic     sclFallTick,
  output logic     sclRiseTick,
  output logic     sdaTick,
  output logic     stretchHold
);
  phase_e phase, phaseNext;
  logic   entry;

  always_comb begin
    stb       = '0;
    phaseNext = phase;
    if (!en) begin
      stb.clrAll = 1'b1;
      phaseNext  = PH_IDLE;
    end else begin
      case (phase)
        PH_IDLE: begin
          stb.enterLow = 1'b1;
          phaseNext    = PH_LOW;
        end
        PH_LOW: begin
          if (lowLast && (sdaDone || sdaFire)) begin
            stb.enterHigh = 1'b1;
            phaseNext     = PH_HIGH;
          end else begin
            stb.incLow = 1'b1;
          end
        end
        PH_HIGH: begin
          if (highLast) begin
            stb.enterLow = 1'b1;
            phaseNext    = PH_LOW;
          end else begin
            stb.incHigh = 1'b1;
          end
        end
        default: phaseNext = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      entry <= 1'b0;
    end else begin
      phase <= phaseNext;
      entry <= (phaseNext != phase) && (phaseNext != PH_IDLE);
    end
  end

  assign sclOut      = (phase != PH_LOW);
  assign sclFallTick = (phase == PH_LOW) && entry;
  assign sclRiseTick = (phase == PH_HIGH) && entry;
  assign sdaTick     = (phase == PH_LOW) && sdaFire;
  assign stretchHold = (phase == PH_HIGH) && !sclIn;

  assert_disable_idles_R10: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> (phase == PH_IDLE) && sclOut);
  assert_hold_keeps_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((phase == PH_HIGH) && !sclIn && en) |=> (phase == PH_HIGH));
  assert_fall_tagged_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclOut) |-> sclFallTick);
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import sclgen_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              en,
  input  logic [WORD_W-1:0] rateWord,
  input  logic [WORD_W-1:0] setupWord,
  input  logic [1:0]        speedMode,
  input  logic              sclIn,
  output logic              sclOut,
  output logic              sclFallTick,
  output logic              sclRiseTick,
  output logic              sdaTick,
  output logic              stretchHold
);
  strobes_t stb;
  logic lowLast, highLast, sdaFire, sdaDone;

  sclgen_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .en(en), .sclIn(sclIn),
    .lowLast(lowLast), .highLast(highLast), .sdaFire(sdaFire), .sdaDone(sdaDone),
    .stb(stb), .sclOut(sclOut), .sclFallTick(sclFallTick),
    .sclRiseTick(sclRiseTick), .sdaTick(sdaTick), .stretchHold(stretchHold)
  );

  sclgen_dp #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sclIn(sclIn),
    .rateWord(rateWord), .setupWord(setupWord), .speedMode(speedMode),
    .lowLast(lowLast), .highLast(highLast), .sdaFire(sdaFire), .sdaDone(sdaDone)
  );
endmodule

// File: tb/scl_timing_gen_test.sv
module scl_timing_gen_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic en = 1'b0;
  logic [31:0] rateWord = 32'd0;
  logic [31:0] setupWord = 32'd0;
  logic [1:0] speedMode = 2'd0;
  logic forceLow = 1'b0;
  logic sclIn, sclOut, sclFallTick, sclRiseTick, sdaTick, stretchHold;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;
  bit finished = 0;

  // reference model state (phase 0 idle, 1 low, 2 high)
  int mPhase = 0, mIdx = 0, mSdaAt = 0, mHigh = 0;
  bit mStretch = 0, mFirst = 0;

  assign sclIn = sclOut & ~forceLow;

  always #10 clk = ~clk;

  scl_timing_gen uut (
    .clk(clk), .rstN(rstN), .en(en), .rateWord(rateWord), .setupWord(setupWord),
    .speedMode(speedMode), .sclIn(sclIn), .sclOut(sclOut), .sclFallTick(sclFallTick),
    .sclRiseTick(sclRiseTick), .sdaTick(sdaTick), .stretchHold(stretchHold)
  );

  always @(posedge clk) begin
    int per, lowLen;
    bit busHigh;
    per     = (rateWord[15:0] == 16'd0) ? 1 : int'(rateWord[15:0]);
    lowLen  = (speedMode == 2'd0) ? per : 2 * per;
    busHigh = (mPhase != 1) && !forceLow;
    if (!rstN || !en) begin
      mPhase = 0; mFirst = 0;
    end else if (mPhase == 0) begin
      mPhase = 1; mIdx = 0; mSdaAt = 0; mFirst = 1;
    end else if (mPhase == 1) begin
      mFirst = 0;
      if (mIdx + 1 >= lowLen && mIdx >= mSdaAt) begin
        mPhase = 2; mHigh = 0; mStretch = 0; mFirst = 1;
      end else mIdx++;
    end else begin
      mFirst = 0;
      if (busHigh) begin
        if (mHigh + 1 == per) begin
          mPhase = 1; mIdx = 0; mFirst = 1;
          mSdaAt = mStretch ? int'(setupWord[31:16]) + 1 : 0;
        end else mHigh++;
      end else mStretch = 1;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      cycles++;
      chk("R1/R3/R4/R10 sclOut", sclOut, mPhase != 1);
      chk("R5 sclFallTick", sclFallTick, mPhase == 1 && mFirst);
      chk("R5 sclRiseTick", sclRiseTick, mPhase == 2 && mFirst);
      chk("R7/R8 sdaTick", sdaTick, mPhase == 1 && mIdx == mSdaAt);
      chk("R6 stretchHold", stretchHold, mPhase == 2 && forceLow);
      if (cycles > 20000) begin
        nFails++; nChecks++;
        $display("FAIL watchdog expired: actual hung expected done");
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
        $finish;
      end
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic configure(input logic [31:0] r, input logic [31:0] s, input logic [1:0] m);
    en = 1'b0; forceLow = 1'b0;
    step(2);
    rateWord = r; setupWord = s; speedMode = m;
    step(1);
    en = 1'b1;
  endtask

  task automatic wait_high();
    for (int i = 0; i < 500 && mPhase != 2; i++) step(1);
  endtask

  task automatic wait_low();
    for (int i = 0; i < 500 && mPhase != 1; i++) step(1);
  endtask

  initial begin
    // R1: reset state
    step(4);
    rstN = 1'b1;
    step(3);
    // R3, R2 (upper half ignored), R9 (setup low half ignored)
    configure(32'hABCD_0003, 32'h0000_FFFF, 2'd0);
    step(40);
    // R2: zero rate behaves as one
    configure(32'h1234_0000, 32'd0, 2'd0);
    step(12);
    // R4: fast, fast-plus, high-speed split
    configure(32'h0000_0002, 32'd0, 2'd1);
    step(30);
    configure(32'h0000_0003, 32'd0, 2'd2);
    step(25);
    configure(32'h0000_0001, 32'd0, 2'd3);
    step(12);
    // R6, R8: stretch with setup 2, R9 low half ones
    configure(32'h0000_0004, 32'h0002_FFFF, 2'd0);
    wait_high(); step(1);
    forceLow = 1'b1; step(5); forceLow = 1'b0;
    step(30);
    // R8: setup 0 still waits one cycle
    configure(32'h0000_0003, 32'h0000_0000, 2'd1);
    wait_high();
    forceLow = 1'b1; step(3); forceLow = 1'b0;
    step(25);
    // R8: long setup extends the low phase
    configure(32'h0000_0002, 32'h000A_0000, 2'd0);
    wait_high();
    forceLow = 1'b1; step(2); forceLow = 1'b0;
    step(40);
    // R10: disable in the middle of a low phase
    configure(32'h0000_0005, 32'd0, 2'd0);
    wait_low(); step(2);
    en = 1'b0; step(4);
    en = 1'b1; step(20);
    // R10: disable while stretched
    wait_high(); forceLow = 1'b1; step(2);
    en = 1'b0; step(3);
    forceLow = 1'b0; step(2);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule